// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches a free-running time base that it shares with other timers and counts expiries of a period chosen by software. It does not count cycles on its own. It picks one of four time-base bits, and every low-to-high transition of that bit is one expiry. The first expiry arms the watchdog and raises an interrupt, so a handler can service it. If a second expiry arrives while the armed status is still set, the block trips. It then raises a reset request that carries a reset type chosen by software.

Software keeps the system alive by pulsing the clear strobe after each interrupt. That returns the watchdog to idle. Once the watchdog trips, the request and its type code are frozen until the block's own reset input clears them. Another part of the chip routes the request to the matching reset domain.

Top module: `wdog_two_stage`

## Requirements
- R1: While `rst` is high at a clock edge, `stat_armed`, `stat_tripped`, `irq`, `rst_req` and `rst_kind` are all 0 after that edge.
- R2: An expiry is a 0-to-1 change, seen between two consecutive clock edges, of time-base bit 17 + 4*`period_sel` (sel 0..3 gives bits 17, 21, 25, 29). Changes on every other time-base bit have no effect.
- R3: An expiry while idle sets `stat_armed` on the edge where the new bit value is first sampled. `irq` is high exactly when `stat_armed` and `irq_en` are both high.
- R4: An expiry while `stat_armed` is set and `clr_armed` is low sets `stat_tripped`. It also latches `rst_type` into `rst_kind` (00 none, 01 core, 10 chip, 11 system). `rst_req` is high when the latched code is not 00.
- R5: A `clr_armed` pulse with no expiry in the same cycle, while not tripped, clears `stat_armed`, so the next expiry counts again as a first expiry.
- R6: A `clr_armed` pulse in the same cycle as an expiry leaves `stat_armed` set and does not trip the watchdog.
- R7: Once tripped, further expiries, `clr_armed` pulses and changes of `rst_type` have no effect, and `rst_req`/`rst_kind` hold until `rst`.
- R8: A trip with `rst_type` = 00 sets `stat_tripped` but keeps `rst_req` low and `rst_kind` at 00.
- R9: A selected bit that is already high while `rst` is applied, or that stays high, gives no expiry. A falling edge gives no expiry either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_bits | input | 32 | Shared time-base value |
| period_sel | input | 2 | Selects the time-base tap that sets the period |
| rst_type | input | 2 | Reset type to issue on trip |
| irq_en | input | 1 | Interrupt enable |
| clr_armed | input | 1 | Strobe that clears the armed status |
| irq | output | 1 | Interrupt request |
| stat_armed | output | 1 | First expiry seen |
| stat_tripped | output | 1 | Second expiry seen, reset pending |
| rst_req | output | 1 | Reset request |
| rst_kind | output | 2 | Type code of the requested reset |

## Verification
A wrong stage state shows up on `stat_armed` or `stat_tripped` one edge after the expiry or clear that caused it. It then shows up on `irq` or `rst_req` in the same cycle. A lost or spurious tap edge moves the trip point by a whole period, so the bench compares every output against a per-cycle model. That model catches the error at the first edge where the design and the model diverge. A corrupted latched type stays wrong on `rst_kind` until reset, so it is visible for the rest of that run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        RK_NONE   = 2'b00,
        RK_CORE   = 2'b01,
        RK_CHIP   = 2'b10,
        RK_SYSTEM = 2'b11
    } rst_kind_e;

    typedef struct packed {
        logic armed;
        logic tripped;
    } wd_stage_t;

    function automatic int unsigned tap_pos(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned idx);
        return base + idx * step;
    endfunction

endpackage

// File: rtl/wdt_tap_edge.sv
module wdt_tap_edge #(
    parameter int unsigned TB_W     = 32,
    parameter int unsigned TAP_BASE = 17,
    parameter int unsigned TAP_STEP = 4,
    parameter int unsigned N_TAPS   = 4,
    localparam int unsigned SEL_W   = $clog2(N_TAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TB_W-1:0]  tb_bits,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    import wdt_pkg::*;

    logic [N_TAPS-1:0] taps;
    logic [N_TAPS-1:0] taps_q;
    logic [N_TAPS-1:0] rise;
    logic              unused_tb;

    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        assign taps[i] = tb_bits[tap_pos(TAP_BASE, TAP_STEP, i)];
    end

    assign unused_tb = ^tb_bits;

    // During reset the history follows the taps, so a bit that is
    // already high at release does not look like a fresh edge.
    always_ff @(posedge clk) begin
        taps_q <= taps;
    end

    assign rise   = taps & ~taps_q;
    assign expire = rise[sel] & ~rst;

endmodule

// File: rtl/wdt_stage_fsm.sv
module wdt_stage_fsm (
    input  logic                clk,
    input  logic                rst,
    input  logic                expire,
    input  logic                clr,
    input  logic [1:0]          type_sel,
    output wdt_pkg::wd_stage_t  stage,
    output wdt_pkg::rst_kind_e  kind
);
    import wdt_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
            kind  <= RK_NONE;
        end else if (!stage.tripped) begin
            if (expire && stage.armed && !clr) begin
                stage.tripped <= 1'b1;
                kind          <= rst_kind_e'(type_sel);
            end else if (expire) begin
                stage.armed <= 1'b1;
            end else if (clr) begin
                stage.armed <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
    parameter int unsigned TB_W     = 32,
    parameter int unsigned TAP_BASE = 17,
    parameter int unsigned TAP_STEP = 4,
    parameter int unsigned N_TAPS   = 4,
    localparam int unsigned SEL_W   = $clog2(N_TAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TB_W-1:0]  tb_bits,
    input  logic [SEL_W-1:0] period_sel,
    input  logic [1:0]       rst_type,
    input  logic             irq_en,
    input  logic             clr_armed,
    output logic             irq,
    output logic             stat_armed,
    output logic             stat_tripped,
    output logic             rst_req,
    output logic [1:0]       rst_kind
);
    import wdt_pkg::*;

    logic       expire;
    wd_stage_t  stage;
    rst_kind_e  kind;

    wdt_tap_edge #(
        .TB_W    (TB_W),
        .TAP_BASE(TAP_BASE),
        .TAP_STEP(TAP_STEP),
        .N_TAPS  (N_TAPS)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .tb_bits(tb_bits),
        .sel    (period_sel),
        .expire (expire)
    );

    wdt_stage_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .expire  (expire),
        .clr     (clr_armed),
        .type_sel(rst_type),
        .stage   (stage),
        .kind    (kind)
    );

    assign stat_armed   = stage.armed;
    assign stat_tripped = stage.tripped;
    assign irq          = stage.armed & irq_en;
    assign rst_req      = stage.tripped && (kind != RK_NONE);
    assign rst_kind     = kind;

endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq_en,
    input logic       clr_armed,
    input logic [1:0] rst_type,
    input logic       irq,
    input logic       stat_armed,
    input logic       stat_tripped,
    input logic       rst_req,
    input logic [1:0] rst_kind
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!stat_armed && !stat_tripped && !rst_req && rst_kind == 2'b00));

    // R3
    irq_needs_armed_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_armed && irq_en));

    // R4
    trip_after_armed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_tripped) |-> ($past(stat_armed) && !$past(clr_armed)));

    // R4
    trip_latches_type_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_tripped) |-> (rst_kind == $past(rst_type)));

    // R7
    trip_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stat_tripped |=> (stat_tripped && $stable(rst_kind) && $stable(rst_req)));

    // R8
    req_has_kind_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (stat_tripped && rst_kind != 2'b00));

    // R8
    no_req_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_tripped |-> (!rst_req && rst_kind == 2'b00));
endmodule

bind wdog_two_stage wdog_two_stage_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_en      (irq_en),
    .clr_armed   (clr_armed),
    .rst_type    (rst_type),
    .irq         (irq),
    .stat_armed  (stat_armed),
    .stat_tripped(stat_tripped),
    .rst_req     (rst_req),
    .rst_kind    (rst_kind)
);

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tbv = '0;
    logic [1:0]  period_sel = '0;
    logic [1:0]  rst_type = '0;
    logic        irq_en = 1'b0;
    logic        clr_armed = 1'b0;
    logic        irq, stat_armed, stat_tripped, rst_req;
    logic [1:0]  rst_kind;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench model state
    logic [3:0] m_prev = '0;
    logic       m_armed = 1'b0, m_trip = 1'b0;
    logic [1:0] m_kind = '0;

    localparam logic [31:0] TAPMASK = (32'd1 << 17) | (32'd1 << 21) | (32'd1 << 25) | (32'd1 << 29);

    always #2 clk = ~clk;

    wdog_two_stage i_wdog_two_stage (
        .clk(clk), .rst(rst), .tb_bits(tbv), .period_sel(period_sel),
        .rst_type(rst_type), .irq_en(irq_en), .clr_armed(clr_armed),
        .irq(irq), .stat_armed(stat_armed), .stat_tripped(stat_tripped),
        .rst_req(rst_req), .rst_kind(rst_kind)
    );

    function automatic logic [3:0] taps_of(input logic [31:0] v);
        return {v[29], v[25], v[21], v[17]};
    endfunction

    function automatic logic [5:0] expected_outs();
        logic req;
        req = m_trip && (m_kind != 2'b00);
        return {m_armed & irq_en, m_armed, m_trip, req, m_kind};
    endfunction

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {irq,armed,trip,req,kind} actual %b expected %b", tag, act, exp);
        end
    endtask

    // one clock: model advances at the edge, outputs compared at the falling edge
    task automatic tick(input string tag);
        logic [3:0] t;
        logic       ex;
        @(posedge clk);
        t = taps_of(tbv);
        if (rst) begin
            m_armed = 0; m_trip = 0; m_kind = 0;
        end else begin
            ex = t[period_sel] & ~m_prev[period_sel];
            if (!m_trip) begin
                if (ex && m_armed && !clr_armed) begin
                    m_trip = 1; m_kind = rst_type;
                end else if (ex) m_armed = 1;
                else if (clr_armed) m_armed = 0;
            end
        end
        m_prev = t;
        @(negedge clk);
        check(tag, {irq, stat_armed, stat_tripped, rst_req, rst_kind}, expected_outs());
    endtask

    task automatic set_tap(input int idx, input logic v);
        tbv[17 + 4*idx] = v;
    endtask

    task automatic expect1(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; clr_armed = 0;
        tick("R1 reset");
        tick("R1 reset");
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        expect1("R1 armed after reset", stat_armed, 1'b0);
        expect1("R1 req after reset", rst_req, 1'b0);

        // R2: other tap ignored
        irq_en = 1; period_sel = 0; rst_type = 2'b10;
        set_tap(1, 1); tick("R2 other tap");
        expect1("R2 other tap no expiry", stat_armed, 1'b0);
        tbv[3] = 1; tbv[18] = 1; tick("R2 untapped bits");
        expect1("R2 untapped bits", stat_armed, 1'b0);
        // R3 first expiry
        set_tap(0, 1); tick("R3 first expiry");
        expect1("R3 armed", stat_armed, 1'b1);
        expect1("R3 irq", irq, 1'b1);
        irq_en = 0; tick("R3 irq masked");
        expect1("R3 irq masked", irq, 1'b0);
        // R9 steady high and falling
        tick("R9 steady high");
        set_tap(0, 0); tick("R9 falling edge");
        expect1("R9 no trip on fall", stat_tripped, 1'b0);
        // R5 clear
        clr_armed = 1; tick("R5 clear"); clr_armed = 0;
        expect1("R5 cleared", stat_armed, 1'b0);
        set_tap(0, 1); tick("R5 first again");
        expect1("R5 first again no trip", stat_tripped, 1'b0);
        expect1("R5 armed again", stat_armed, 1'b1);
        // R4 second expiry trips
        set_tap(0, 0); tick("R4 low");
        set_tap(0, 1); tick("R4 second expiry");
        expect1("R4 tripped", stat_tripped, 1'b1);
        expect1("R4 req", rst_req, 1'b1);
        expect1("R4 kind hi", rst_kind[1], 1'b1);
        // R7 frozen
        rst_type = 2'b01; clr_armed = 1; set_tap(0, 0); tick("R7 hold");
        clr_armed = 0; set_tap(0, 1); tick("R7 hold");
        expect1("R7 kind kept", rst_kind == 2'b10, 1'b1);
        expect1("R7 req kept", rst_req, 1'b1);

        // R9 tap high during reset
        set_tap(3, 1); period_sel = 3;
        do_reset();
        tick("R9 high through reset");
        expect1("R9 no expiry after reset", stat_armed, 1'b0);
        // R2 period 3 uses bit 29
        set_tap(3, 0); tick("R2 bit29 low");
        set_tap(3, 1); tick("R2 bit29 rise");
        expect1("R2 bit29 arms", stat_armed, 1'b1);
        // R6 clear with expiry
        set_tap(3, 0); tick("R6 low");
        set_tap(3, 1); clr_armed = 1; tick("R6 clear with expiry"); clr_armed = 0;
        expect1("R6 still armed", stat_armed, 1'b1);
        expect1("R6 not tripped", stat_tripped, 1'b0);
        // R8 type none
        rst_type = 2'b00;
        set_tap(3, 0); tick("R8 low");
        set_tap(3, 1); tick("R8 trip none");
        expect1("R8 tripped", stat_tripped, 1'b1);
        expect1("R8 no req", rst_req, 1'b0);
        expect1("R8 kind none", rst_kind == 2'b00, 1'b1);

        // random phase against the model
        do_reset();
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(3) == 0) begin
                int k;
                k = $urandom_range(3);
                tbv[17 + 4*k] = ~tbv[17 + 4*k];
            end
            tbv = ($urandom() & ~TAPMASK) | (tbv & TAPMASK);
            clr_armed = ($urandom_range(7) == 0);
            rst_type  = 2'($urandom_range(3));
            if ($urandom_range(31) == 0) irq_en = ~irq_en;
            if ($urandom_range(63) == 0) period_sel = 2'($urandom_range(3));
            rst = ($urandom_range(199) == 0);
            tick("R2/R3/R4/R5/R6/R7 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule